// File: doc/BRIEF.md
# Composite Sync Pulse Classifier

This block watches an active-low composite sync stream that is already synchronous to a clock running at four times the colour subcarrier. It measures how many clock cycles each negative-going pulse lasts. When the pulse ends, it sorts the pulse into one of four classes: a valid horizontal sync, a short equalizing pulse, a broad vertical or serration pulse, or an out-of-spec pulse that is dropped without any trace. Only an accepted horizontal sync opens a colour burst gate. The gate opens a fixed number of clocks after that pulse's leading edge and stays open for a fixed number of clocks.

A small field tracker follows the classification stream. It raises a field start on the first broad pulse that follows an equalizing pulse. On every second field it also raises a frame start, which downstream subcarrier phase logic can use to re-align. A select input picks one of two timing sets, held as parameters in clocks: high selects the 525-line (NTSC) set and low selects the 625-line (PAL) set. The select input is read live, so it is meant to change only between pulses.

The controller is a five-state machine:
- `ST_ARM` waits after reset for the line to be seen high.
- `ST_IDLE` waits for a leading edge.
- `ST_LOW` counts the pulse width.
- `ST_WAIT` keeps counting from the leading edge until the burst start.
- `ST_BURST` holds the gate open.

The transitions are:
- arm→idle on a high sample.
- idle→low on a low sample.
- low→wait on a trailing edge whose width is accepted as horizontal sync.
- low→idle on any other trailing edge.
- wait→burst when the age count reaches the burst start.
- burst→idle when the burst length is used up.
- wait→low and burst→low on a new low sample, which abandons the burst.

Top module: `csync_classifier`

## Requirements
- R1: The synchronous active-high reset drives every output low on the next edge and clears all counters. A pulse that is low while reset is released is discarded: no output reacts until `sync_n` has been sampled high once.
- R2: The pulse width is the number of consecutive rising edges at which `sync_n` is sampled low. Exactly one classification output pulses for one cycle, in the cycle after the first edge at which `sync_n` is sampled high again.
- R3: `hsync_ok` pulses when the width is between HMIN and HMAX inclusive, using the timing set currently selected.
- R4: `equalize_det` pulses when the width is below HMIN.
- R5: `broad_det` pulses when the width is at least BROAD.
- R6: A width above HMAX and below BROAD raises no output, opens no burst, and leaves the field tracker's memory of a preceding equalizing pulse intact.
- R7: After an accepted horizontal sync whose first low sample was at edge E0, `burst_gate` is high for exactly BLEN cycles. It goes high in the cycle after edge E0+BSTART. BSTART must exceed HMAX.
- R8: A low sample while the gate is pending or open abandons that burst. `burst_gate` is low in the following cycle and that pulse is measured afresh.
- R9: `field_start` pulses together with `broad_det` on the first broad pulse after an equalizing pulse. An accepted horizontal sync clears the memory of that equalizing pulse, and a broad pulse without it raises nothing.
- R10: `frame_start` pulses together with `field_start` on the first field after reset and on every second field after that.
- R11: `ntsc_sel` high selects the NTSC timing parameters, and low selects the PAL timing parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the colour subcarrier |
| rst | input | 1 | Synchronous reset, active high |
| sync_n | input | 1 | Composite sync, active low, synchronous to clk |
| ntsc_sel | input | 1 | Timing set select: 1 = NTSC, 0 = PAL |
| hsync_ok | output | 1 | One-cycle pulse: accepted horizontal sync |
| equalize_det | output | 1 | One-cycle pulse: short equalizing pulse |
| broad_det | output | 1 | One-cycle pulse: broad vertical or serration pulse |
| burst_gate | output | 1 | High while the colour burst is to be inserted |
| field_start | output | 1 | One-cycle pulse at the start of a field |
| frame_start | output | 1 | One-cycle pulse at the start of a frame |

## Verification
The bench builds the block with an 8-bit counter and compressed timing sets:
- NTSC: HMIN 8, HMAX 12, BROAD 24, BSTART 15, BLEN 6.
- PAL: HMIN 10, HMAX 15, BROAD 30, BSTART 18, BLEN 8.

These small values keep every window boundary within a few cycles of each other. A random run of a few hundred pulses therefore lands often on each edge of each window, on rejected widths, and on new pulses that cut into a pending or open burst. The two sets differ in every bound, so a wrong standard mux shows up directly in the classes and in the burst position.

// File: rtl/csc_pkg.sv
package csc_pkg;

    typedef enum logic [2:0] {
        ST_ARM   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_LOW   = 3'd2,
        ST_WAIT  = 3'd3,
        ST_BURST = 3'd4
    } csc_state_e;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_EQ    = 2'd1,
        CLS_HSYNC = 2'd2,
        CLS_BROAD = 2'd3
    } csc_class_e;

    typedef struct packed {
        logic hsync;
        logic equalize;
        logic broad;
    } csc_det_t;

endpackage

// File: rtl/csc_timing_sel.sv
module csc_timing_sel #(
    parameter int CNT_W       = 10,
    parameter int NTSC_HMIN   = 60,
    parameter int NTSC_HMAX   = 74,
    parameter int NTSC_BROAD  = 200,
    parameter int NTSC_BSTART = 76,
    parameter int NTSC_BLEN   = 32,
    parameter int PAL_HMIN    = 74,
    parameter int PAL_HMAX    = 92,
    parameter int PAL_BROAD   = 240,
    parameter int PAL_BSTART  = 97,
    parameter int PAL_BLEN    = 40
) (
    input  logic             ntsc_sel,
    output logic [CNT_W-1:0] hmin_o,
    output logic [CNT_W-1:0] hmax_o,
    output logic [CNT_W-1:0] broad_o,
    output logic [CNT_W-1:0] bstart_o,
    output logic [CNT_W-1:0] blen_o
);

    localparam logic [CNT_W-1:0] N_HMIN   = CNT_W'(NTSC_HMIN);
    localparam logic [CNT_W-1:0] N_HMAX   = CNT_W'(NTSC_HMAX);
    localparam logic [CNT_W-1:0] N_BROAD  = CNT_W'(NTSC_BROAD);
    localparam logic [CNT_W-1:0] N_BSTART = CNT_W'(NTSC_BSTART);
    localparam logic [CNT_W-1:0] N_BLEN   = CNT_W'(NTSC_BLEN);
    localparam logic [CNT_W-1:0] P_HMIN   = CNT_W'(PAL_HMIN);
    localparam logic [CNT_W-1:0] P_HMAX   = CNT_W'(PAL_HMAX);
    localparam logic [CNT_W-1:0] P_BROAD  = CNT_W'(PAL_BROAD);
    localparam logic [CNT_W-1:0] P_BSTART = CNT_W'(PAL_BSTART);
    localparam logic [CNT_W-1:0] P_BLEN   = CNT_W'(PAL_BLEN);

    // Select input high picks the 525-line set, low the 625-line set.
    always_comb begin
        if (ntsc_sel) begin
            hmin_o   = N_HMIN;
            hmax_o   = N_HMAX;
            broad_o  = N_BROAD;
            bstart_o = N_BSTART;
            blen_o   = N_BLEN;
        end else begin
            hmin_o   = P_HMIN;
            hmax_o   = P_HMAX;
            broad_o  = P_BROAD;
            bstart_o = P_BSTART;
            blen_o   = P_BLEN;
        end
    end

endmodule

// File: rtl/csc_pulse_fsm.sv
module csc_pulse_fsm
    import csc_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_n,
    input  logic [CNT_W-1:0] hmin,
    input  logic [CNT_W-1:0] hmax,
    input  logic [CNT_W-1:0] broad,
    input  logic [CNT_W-1:0] bstart,
    input  logic [CNT_W-1:0] blen,
    output csc_det_t         det_o,
    output logic             burst_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    csc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] bcnt_q;
    logic [CNT_W-1:0] cnt_inc;
    csc_class_e       cls;
    logic             trailing;

    // Saturating age counter: width while low, age since leading edge after.
    assign cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
    assign trailing = (state_q == ST_LOW) && sync_n;

    // Width classification, valid at the trailing edge.
    always_comb begin
        if (cnt_q < hmin) begin
            cls = CLS_EQ;
        end else if (cnt_q <= hmax) begin
            cls = CLS_HSYNC;
        end else if (cnt_q >= broad) begin
            cls = CLS_BROAD;
        end else begin
            cls = CLS_NONE;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARM: begin
                if (sync_n) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (!sync_n) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (sync_n) begin
                    state_d = (cls == CLS_HSYNC) ? ST_WAIT : ST_IDLE;
                end
            end
            ST_WAIT: begin
                if (!sync_n) begin
                    state_d = ST_LOW;
                end else if (cnt_q == bstart) begin
                    state_d = ST_BURST;
                end
            end
            ST_BURST: begin
                if (!sync_n) begin
                    state_d = ST_LOW;
                end else if (bcnt_q == blen) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_ARM;
        endcase
    end

    // State register and counters.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ARM;
            cnt_q   <= '0;
            bcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if ((state_d == ST_LOW) && (state_q != ST_LOW)) begin
                cnt_q <= CNT_ONE;
            end else if ((state_q == ST_LOW) || (state_q == ST_WAIT)) begin
                cnt_q <= cnt_inc;
            end
            if ((state_d == ST_BURST) && (state_q != ST_BURST)) begin
                bcnt_q <= CNT_ONE;
            end else if (state_q == ST_BURST) begin
                bcnt_q <= bcnt_q + CNT_ONE;
            end
        end
    end

    // Registered one-cycle classification outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            det_o <= '0;
        end else begin
            det_o.hsync    <= trailing && (cls == CLS_HSYNC);
            det_o.equalize <= trailing && (cls == CLS_EQ);
            det_o.broad    <= trailing && (cls == CLS_BROAD);
        end
    end

    assign burst_o = (state_q == ST_BURST);

endmodule

// File: rtl/csc_field_track.sv
module csc_field_track (
    input  logic clk,
    input  logic rst,
    input  logic eq_det,
    input  logic hs_det,
    input  logic br_det,
    output logic field_o,
    output logic frame_o
);

    logic eq_seen_q;
    logic odd_q;

    assign field_o = br_det && eq_seen_q;
    assign frame_o = field_o && !odd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            eq_seen_q <= 1'b0;
            odd_q     <= 1'b0;
        end else if (field_o) begin
            eq_seen_q <= 1'b0;
            odd_q     <= !odd_q;
        end else if (eq_det) begin
            eq_seen_q <= 1'b1;
        end else if (hs_det) begin
            eq_seen_q <= 1'b0;
        end
    end

endmodule

// File: rtl/csync_classifier.sv
module csync_classifier
    import csc_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int NTSC_HMIN   = 60,
    parameter int NTSC_HMAX   = 74,
    parameter int NTSC_BROAD  = 200,
    parameter int NTSC_BSTART = 76,
    parameter int NTSC_BLEN   = 32,
    parameter int PAL_HMIN    = 74,
    parameter int PAL_HMAX    = 92,
    parameter int PAL_BROAD   = 240,
    parameter int PAL_BSTART  = 97,
    parameter int PAL_BLEN    = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_n,
    input  logic ntsc_sel,
    output logic hsync_ok,
    output logic equalize_det,
    output logic broad_det,
    output logic burst_gate,
    output logic field_start,
    output logic frame_start
);

    logic [CNT_W-1:0] hmin, hmax, broad, bstart, blen;
    csc_det_t         det;

    csc_timing_sel #(
        .CNT_W      (CNT_W),
        .NTSC_HMIN  (NTSC_HMIN),
        .NTSC_HMAX  (NTSC_HMAX),
        .NTSC_BROAD (NTSC_BROAD),
        .NTSC_BSTART(NTSC_BSTART),
        .NTSC_BLEN  (NTSC_BLEN),
        .PAL_HMIN   (PAL_HMIN),
        .PAL_HMAX   (PAL_HMAX),
        .PAL_BROAD  (PAL_BROAD),
        .PAL_BSTART (PAL_BSTART),
        .PAL_BLEN   (PAL_BLEN)
    ) u_sel (
        .ntsc_sel(ntsc_sel),
        .hmin_o  (hmin),
        .hmax_o  (hmax),
        .broad_o (broad),
        .bstart_o(bstart),
        .blen_o  (blen)
    );

    csc_pulse_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .sync_n (sync_n),
        .hmin   (hmin),
        .hmax   (hmax),
        .broad  (broad),
        .bstart (bstart),
        .blen   (blen),
        .det_o  (det),
        .burst_o(burst_gate)
    );

    csc_field_track u_field (
        .clk    (clk),
        .rst    (rst),
        .eq_det (det.equalize),
        .hs_det (det.hsync),
        .br_det (det.broad),
        .field_o(field_start),
        .frame_o(frame_start)
    );

    assign hsync_ok     = det.hsync;
    assign equalize_det = det.equalize;
    assign broad_det    = det.broad;

endmodule

// File: rtl/csc_checker.sv
module csc_checker #(
    parameter int BLEN_MAX = 40
) (
    input logic clk,
    input logic rst,
    input logic sync_n,
    input logic hsync_ok,
    input logic equalize_det,
    input logic broad_det,
    input logic burst_gate,
    input logic field_start,
    input logic frame_start
);

    logic prev_sync_q;
    logic hs_armed_q;
    int   run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sync_q <= 1'b1;
            hs_armed_q  <= 1'b0;
            run_q       <= 0;
        end else begin
            prev_sync_q <= sync_n;
            if (!sync_n && prev_sync_q) begin
                hs_armed_q <= 1'b0;
            end else if (hsync_ok) begin
                hs_armed_q <= 1'b1;
            end
            run_q <= burst_gate ? run_q + 1 : 0;
        end
    end

    assert_cls_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hsync_ok, equalize_det, broad_det}));

    assert_cls_after_rise_R2: assert property (@(posedge clk) disable iff (rst)
        (hsync_ok || equalize_det || broad_det) |-> ($past(sync_n) && !$past(sync_n, 2)));

    assert_burst_after_hsync_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(burst_gate) |-> hs_armed_q);

    assert_burst_len_R7: assert property (@(posedge clk) disable iff (rst)
        burst_gate |-> (run_q < BLEN_MAX));

    assert_burst_abort_R8: assert property (@(posedge clk) disable iff (rst)
        (burst_gate && !sync_n) |=> !burst_gate);

    assert_field_on_broad_R9: assert property (@(posedge clk) disable iff (rst)
        field_start |-> broad_det);

    assert_frame_on_field_R10: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> field_start);

endmodule

bind csync_classifier csc_checker #(
    .BLEN_MAX((NTSC_BLEN > PAL_BLEN) ? NTSC_BLEN : PAL_BLEN)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sync_n      (sync_n),
    .hsync_ok    (hsync_ok),
    .equalize_det(equalize_det),
    .broad_det   (broad_det),
    .burst_gate  (burst_gate),
    .field_start (field_start),
    .frame_start (frame_start)
);

// File: tb/csync_classifier_tb.sv
module csync_classifier_tb;

    localparam int N_HMIN = 8,  N_HMAX = 12, N_BROAD = 24, N_BS = 15, N_BL = 6;
    localparam int P_HMIN = 10, P_HMAX = 15, P_BROAD = 30, P_BS = 18, P_BL = 8;
    localparam int K_CAP  = 1 << 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_n = 1'b1;
    logic ntsc_sel = 1'b1;
    logic hsync_ok, equalize_det, broad_det, burst_gate, field_start, frame_start;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int ev_cnt = 0;
    int fs_cnt = 0;
    int fr_cnt = 0;

    always #5 clk = ~clk;

    csync_classifier #(
        .CNT_W(8),
        .NTSC_HMIN(N_HMIN), .NTSC_HMAX(N_HMAX), .NTSC_BROAD(N_BROAD),
        .NTSC_BSTART(N_BS), .NTSC_BLEN(N_BL),
        .PAL_HMIN(P_HMIN), .PAL_HMAX(P_HMAX), .PAL_BROAD(P_BROAD),
        .PAL_BSTART(P_BS), .PAL_BLEN(P_BL)
    ) u_dut (
        .clk(clk), .rst(rst), .sync_n(sync_n), .ntsc_sel(ntsc_sel),
        .hsync_ok(hsync_ok), .equalize_det(equalize_det), .broad_det(broad_det),
        .burst_gate(burst_gate), .field_start(field_start), .frame_start(frame_start)
    );

    function automatic int f_hmin(bit n);  return n ? N_HMIN  : P_HMIN;  endfunction
    function automatic int f_hmax(bit n);  return n ? N_HMAX  : P_HMAX;  endfunction
    function automatic int f_broad(bit n); return n ? N_BROAD : P_BROAD; endfunction
    function automatic int f_bs(bit n);    return n ? N_BS    : P_BS;    endfunction
    function automatic int f_bl(bit n);    return n ? N_BL    : P_BL;    endfunction

    // 0 = ignored, 1 = equalizing, 2 = horizontal, 3 = broad
    function automatic int classify(int w, bit n);
        if (w < f_hmin(n)) return 1;
        if (w <= f_hmax(n)) return 2;
        if (w >= f_broad(n)) return 3;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected outputs, derived from the requirements at each edge.
    bit m_armed, m_low, m_hs, m_eq, m_odd;
    int m_wid, m_k;
    bit e_hs, e_eq, e_br, e_gate, e_fs, e_fr;

    always @(posedge clk) begin : model
        int c;
        e_hs = 0; e_eq = 0; e_br = 0; e_fs = 0; e_fr = 0;
        if (rst) begin
            m_armed = 0; m_low = 0; m_hs = 0; m_eq = 0; m_odd = 0;
            m_wid = 0; m_k = K_CAP;
        end else if (!m_armed) begin
            if (sync_n) m_armed = 1;
        end else if (!sync_n) begin
            if (!m_low) begin
                m_low = 1; m_wid = 1; m_k = 0; m_hs = 0;
            end else begin
                m_wid++; m_k++;
            end
        end else begin
            if (m_low) begin
                m_low = 0;
                c = classify(m_wid, ntsc_sel);
                e_eq = (c == 1); e_hs = (c == 2); e_br = (c == 3);
                m_hs = e_hs;
                if (e_eq) m_eq = 1;
                if (e_hs) m_eq = 0;
                if (e_br && m_eq) begin
                    e_fs = 1; e_fr = !m_odd; m_odd = !m_odd; m_eq = 0;
                end
            end
            if (m_k < K_CAP) m_k++;
        end
        e_gate = m_hs && !m_low && (m_k >= f_bs(ntsc_sel)) &&
                 (m_k <= f_bs(ntsc_sel) + f_bl(ntsc_sel) - 1);
    end

    bit started = 0;
    always @(negedge clk) begin
        if (hsync_ok || equalize_det || broad_det || burst_gate || field_start || frame_start)
            ev_cnt++;
        if (field_start) fs_cnt++;
        if (frame_start) fr_cnt++;
        if (started && !done) begin
            check(hsync_ok == e_hs,       "R3 hsync_ok",      int'(hsync_ok),     int'(e_hs));
            check(equalize_det == e_eq,   "R4 equalize_det",  int'(equalize_det), int'(e_eq));
            check(broad_det == e_br,      "R5 broad_det",     int'(broad_det),    int'(e_br));
            check(burst_gate == e_gate,   "R7,R8 burst_gate", int'(burst_gate),   int'(e_gate));
            check(field_start == e_fs,    "R9 field_start",   int'(field_start),  int'(e_fs));
            check(frame_start == e_fr,    "R10 frame_start",  int'(frame_start),  int'(e_fr));
        end
    end

    task automatic pulse(input int w, input int gap);
        sync_n = 1'b0;
        repeat (w) @(negedge clk);
        sync_n = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    // Boundary width: sample the class in the cycle after the trailing edge.
    task automatic bound(input int w, input bit n);
        int got, exp;
        ntsc_sel = n;
        sync_n = 1'b0;
        repeat (w) @(negedge clk);
        sync_n = 1'b1;
        @(negedge clk);
        got = hsync_ok ? 2 : equalize_det ? 1 : broad_det ? 3 : 0;
        exp = classify(w, n);
        check(got == exp, "R11 class (R3 R4 R5 R6)", got, exp);
        @(negedge clk);
        check(!(hsync_ok || equalize_det || broad_det), "R2 single-cycle class", 1, 0);
        repeat (40) @(negedge clk);
    endtask

    task automatic burst_shape(input bit n);
        int w, first, len;
        ntsc_sel = n;
        w = f_hmin(n);
        first = -1; len = 0;
        sync_n = 1'b0;
        repeat (w) @(negedge clk);
        sync_n = 1'b1;
        @(negedge clk);
        check(hsync_ok == 1'b1, "R2 hsync timing", int'(hsync_ok), 1);
        for (int j = 1; j <= f_bs(n) + f_bl(n) + 5; j++) begin
            @(negedge clk);
            if (burst_gate) begin
                if (first < 0) first = j;
                len++;
            end
        end
        check(first == f_bs(n) - w, "R7 burst start", first, f_bs(n) - w);
        check(len == f_bl(n), "R7 burst length", len, f_bl(n));
        repeat (5) @(negedge clk);
    endtask

    task automatic vseq();
        repeat (4) pulse(N_HMIN + 1, 40);
        repeat (6) pulse(3, 20);
        repeat (6) pulse(N_BROAD + 5, 6);
        repeat (6) pulse(3, 20);
        repeat (3) pulse(N_HMIN + 1, 40);
    endtask

    initial begin
        int ev0, fs0, fr0, w, gap, cat;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        started = 1;
        // R1: outputs low in reset
        check(!(hsync_ok || equalize_det || broad_det || burst_gate || field_start || frame_start),
              "R1 reset outputs", 1, 0);
        // R1: pulse in progress across reset release is discarded
        sync_n = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        ev0 = ev_cnt;
        repeat (12) @(negedge clk);
        sync_n = 1'b1;
        repeat (30) @(negedge clk);
        check(ev_cnt == ev0, "R1 discard pulse at reset", ev_cnt - ev0, 0);

        // R9 R10: two vertical intervals, NTSC
        ntsc_sel = 1'b1;
        fs0 = fs_cnt; fr0 = fr_cnt;
        vseq();
        vseq();
        check(fs_cnt - fs0 == 2, "R9 field count", fs_cnt - fs0, 2);
        check(fr_cnt - fr0 == 1, "R10 frame count", fr_cnt - fr0, 1);

        // R9: broad without preceding equalizing raises no field
        fs0 = fs_cnt;
        pulse(N_HMIN, 40);
        pulse(N_BROAD + 2, 10);
        check(fs_cnt == fs0, "R9 broad without eq", fs_cnt - fs0, 0);

        // R6: rejected pulse makes no output and keeps eq memory
        ev0 = ev_cnt;
        pulse(N_HMAX + 2, 40);
        check(ev_cnt == ev0, "R6 rejected pulse silent", ev_cnt - ev0, 0);
        fs0 = fs_cnt;
        pulse(3, 20);
        pulse(N_HMAX + 3, 20);
        pulse(N_BROAD, 20);
        check(fs_cnt - fs0 == 1, "R6 eq memory kept", fs_cnt - fs0, 1);

        // Boundaries for both timing sets (R3 R4 R5 R6 R11)
        for (int s = 0; s < 2; s++) begin
            bit n;
            n = (s == 0);
            bound(f_hmin(n) - 1, n);
            bound(f_hmin(n), n);
            bound(f_hmax(n), n);
            bound(f_hmax(n) + 1, n);
            bound(f_broad(n) - 1, n);
            bound(f_broad(n), n);
            burst_shape(n);
        end

        // R8: new leading edge while burst open
        ntsc_sel = 1'b1;
        w = N_HMAX;
        sync_n = 1'b0;
        repeat (w) @(negedge clk);
        sync_n = 1'b1;
        repeat (N_BS - w + 1) @(negedge clk);
        check(burst_gate == 1'b1, "R7 gate open", int'(burst_gate), 1);
        sync_n = 1'b0;
        @(negedge clk);
        check(burst_gate == 1'b0, "R8 gate cut", int'(burst_gate), 0);
        repeat (2) @(negedge clk);
        sync_n = 1'b1;
        repeat (40) @(negedge clk);

        // Random pulse stream
        for (int i = 0; i < 400; i++) begin
            if ($urandom % 12 == 0) begin
                repeat (60) @(negedge clk);
                ntsc_sel = ~ntsc_sel;
            end
            cat = $urandom % 6;
            case (cat)
                0: w = 1 + $urandom % (f_hmin(ntsc_sel) - 1);
                1, 2: w = f_hmin(ntsc_sel) + $urandom % (f_hmax(ntsc_sel) - f_hmin(ntsc_sel) + 1);
                3: w = f_hmax(ntsc_sel) + 1 + $urandom % (f_broad(ntsc_sel) - f_hmax(ntsc_sel) - 1);
                4: w = f_broad(ntsc_sel) + $urandom % 20;
                default: w = f_hmin(ntsc_sel) - 1 + ($urandom % 3) * (f_hmax(ntsc_sel) - f_hmin(ntsc_sel) + 1);
            endcase
            gap = 1 + $urandom % 45;
            pulse(w, gap);
        end
        repeat (60) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule